// File: doc/BRIEF.md
# BCD Clock Calendar Update Engine

This block keeps wall-clock time and calendar date in packed BCD registers. The fields are seconds, minutes, hours (24-hour), day of week, day of month, month, two-digit year and a century byte. A prescaler supplies a one-cycle pulse once per second. On each accepted pulse the engine raises an update-in-progress flag. A fixed number of clock cycles later it moves every counter forward in one step, carrying from seconds up to the century. It then signals the end of the update and checks the new time against three alarm bytes. An alarm byte acts as a wildcard when its two top bits are both set.

Software reaches every register through a synchronous port. It drives an address, write data and a write enable, and it sees the read data combinationally. A hold bit in a control register stops all updates, so software can load a new time without a carry landing part-way through. The control registers stay readable and writable while an update is pending. Flags for the end of an update and for an alarm match sit in a status byte. Software clears them by writing a one to the flag's bit.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the address map reads as follows. Address 0x06 (day of week), 0x07 (date) and 0x08 (month) read 0x01, and address 0x32 (century) reads 0x20. Addresses 0x00 (seconds), 0x01 (seconds alarm), 0x02 (minutes), 0x03 (minutes alarm), 0x04 (hours), 0x05 (hours alarm), 0x09 (year) and the control bytes 0x0A, 0x0B, 0x0C and 0x0D read 0x00. Every unmapped address reads 0x00 and ignores writes.
- R2: With the hold bit clear, each accepted tick adds one second in BCD. Seconds and minutes wrap 59→00 and carry. Hours wrap 23→00 and carry into the day of week (7→1) and into the date.
- R3: While bit 7 of 0x0B (hold) is 1, a tick is ignored and the update flag stays 0. Setting hold while an update is pending cancels that update without changing any counter.
- R4: Bit 7 of 0x0A reads 1 for exactly UIP_LEAD cycles, starting in the cycle after the tick is sampled. It also appears on uip_o. The counters change at the clock edge where the flag falls. Writes to bit 7 of 0x0A have no effect.
- R5: update_done_o is high for the single cycle after the counters change, and bit 1 of 0x0C is set at the same edge. Writing 1 to bit 1 of 0x0C clears it. A set in the same cycle takes priority over the clear.
- R6: The date wraps to 01 and carries into the month after day 30 for months 04, 06, 09 and 11. February wraps after day 29 when the year is divisible by 4 and after day 28 otherwise. All other months wrap after day 31.
- R7: When an update takes the year from 99 to 00, the month from 12 to 01 and the date to 01, the century register at 0x32 is loaded with 0x20.
- R8: Bit 7 of a write to seconds is stored as 0. The other time and date registers keep unused bits that software writes as 1 until the next update, which clears them. The kept masks are 0x7F for minutes, 0x3F for hours, 0x07 for day of week, 0x3F for date and 0x1F for month.
- R9: At each update, bit 0 of 0x0C is set and alarm_o pulses with update_done_o when the new seconds, minutes and hours each match their alarm byte. An alarm byte matches when it equals the new value or when its bits 7:6 are 11. Writing 1 to bit 0 clears the flag.
- R10: Control bytes 0x0A (bits 6:0), 0x0B and 0x0D are writable and read back while the update flag is high. A tick that arrives while an update is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| we_i | input | 1 | Register write enable |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for addr_i |
| uip_o | output | 1 | Update in progress |
| update_done_o | output | 1 | One-cycle pulse after the counters change |
| alarm_o | output | 1 | One-cycle pulse when an update matches the alarm |

## Verification
The hardest situations to reach are the long carry chains: a single tick that rolls every field from seconds through the century, and the February length that depends on the year. The bench reaches them by loading the register set one step before each rollover and then issuing one tick. The window where hold cancels a pending update is also narrow. The bench reaches it by writing the hold bit one cycle after the tick, while the update flag is still high.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int REG_SEC   = 8'h00;
  localparam int REG_ASEC  = 8'h01;
  localparam int REG_MIN   = 8'h02;
  localparam int REG_AMIN  = 8'h03;
  localparam int REG_HOUR  = 8'h04;
  localparam int REG_AHOUR = 8'h05;
  localparam int REG_DOW   = 8'h06;
  localparam int REG_DATE  = 8'h07;
  localparam int REG_MON   = 8'h08;
  localparam int REG_YEAR  = 8'h09;
  localparam int REG_CA    = 8'h0A;
  localparam int REG_CB    = 8'h0B;
  localparam int REG_CC    = 8'h0C;
  localparam int REG_CD    = 8'h0D;
  localparam int REG_CENT  = 8'h32;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
    return {b[7:4], b[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mo, input logic [7:0] y);
    case (mo)
      8'h02: return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int UIP_LEAD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  output logic uip_o,
  output logic adv_o
);
  localparam int CNT_W = (UIP_LEAD > 1) ? $clog2(UIP_LEAD) : 1;

  logic             pending_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last  = (cnt_q == CNT_W'(UIP_LEAD - 1));
  assign adv_o = pending_q && last && !hold_i;
  assign uip_o = pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (pending_q) begin
      if (hold_i || last) pending_q <= 1'b0;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (tick_i && !hold_i) begin
      pending_q <= 1'b1;
      cnt_q     <= '0;
    end
  end

  assert_hold_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !pending_q) |=> !pending_q);
  // R4: flag only drops through a transfer or a cancel
  assert_uip_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pending_q) |-> ($past(adv_o) || $past(hold_i)));
  assert_tick_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !last && !hold_i) |=> pending_q);
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_bcd_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output rtc_time_t         time_o,
  output logic [7:0]        nx_sec_o,
  output logic [7:0]        nx_min_o,
  output logic [7:0]        nx_hour_o
);
  rtc_time_t t_q, nx;
  logic [7:0] s, m, h, w, d, mo, y, dim;
  logic c1, c2, c3, c4, c5, c6;

  function automatic logic hit(input int a);
    return we_i && (addr_i == ADDR_W'(a));
  endfunction

  always_comb begin
    s  = t_q.sec & 8'h7F;
    m  = t_q.minute & 8'h7F;
    h  = t_q.hour & 8'h3F;
    w  = t_q.dow & 8'h07;
    d  = t_q.date & 8'h3F;
    mo = t_q.mon & 8'h1F;
    y  = t_q.year;
    dim = month_days(mo, y);
    c1 = (s == 8'h59);
    c2 = c1 && (m == 8'h59);
    c3 = c2 && (h == 8'h23);
    c4 = c3 && (d == dim);
    c5 = c4 && (mo == 8'h12);
    c6 = c5 && (y == 8'h99);
    nx.sec    = c1 ? 8'h00 : (bcd_inc(s) & 8'h7F);
    nx.minute = c1 ? ((m == 8'h59) ? 8'h00 : bcd_inc(m)) : m;
    nx.hour   = c2 ? ((h == 8'h23) ? 8'h00 : bcd_inc(h)) : h;
    nx.dow    = c3 ? ((w >= 8'h07) ? 8'h01 : w + 8'h01) : w;
    nx.date   = c3 ? ((d == dim) ? 8'h01 : bcd_inc(d)) : d;
    nx.mon    = c4 ? ((mo == 8'h12) ? 8'h01 : bcd_inc(mo)) : mo;
    nx.year   = c5 ? ((y == 8'h99) ? 8'h00 : bcd_inc(y)) : y;
    nx.cent   = c6 ? 8'h20 : t_q.cent;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q.sec    <= 8'h00;
      t_q.minute <= 8'h00;
      t_q.hour   <= 8'h00;
      t_q.dow    <= 8'h01;
      t_q.date   <= 8'h01;
      t_q.mon    <= 8'h01;
      t_q.year   <= 8'h00;
      t_q.cent   <= 8'h20;
    end else begin
      if (hit(REG_SEC))       t_q.sec    <= wdata_i & 8'h7F;
      else if (adv_i)         t_q.sec    <= nx.sec;
      if (hit(REG_MIN))       t_q.minute <= wdata_i;
      else if (adv_i)         t_q.minute <= nx.minute;
      if (hit(REG_HOUR))      t_q.hour   <= wdata_i;
      else if (adv_i)         t_q.hour   <= nx.hour;
      if (hit(REG_DOW))       t_q.dow    <= wdata_i;
      else if (adv_i)         t_q.dow    <= nx.dow;
      if (hit(REG_DATE))      t_q.date   <= wdata_i;
      else if (adv_i)         t_q.date   <= nx.date;
      if (hit(REG_MON))       t_q.mon    <= wdata_i;
      else if (adv_i)         t_q.mon    <= nx.mon;
      if (hit(REG_YEAR))      t_q.year   <= wdata_i;
      else if (adv_i)         t_q.year   <= nx.year;
      if (hit(REG_CENT))      t_q.cent   <= wdata_i;
      else if (adv_i)         t_q.cent   <= nx.cent;
    end
  end

  assign time_o    = t_q;
  assign nx_sec_o  = nx.sec;
  assign nx_min_o  = nx.minute;
  assign nx_hour_o = nx.hour;

  assert_sec_bit7_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_q.sec[7] == 1'b0);
  assert_sec_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !hit(REG_SEC)) |=> $stable(t_q.sec));
  assert_century_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && c6 && !hit(REG_CENT)) |=> (t_q.cent == 8'h20));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int N_FIELDS = 3
) (
  input  logic [N_FIELDS*8-1:0] now_i,
  input  logic [N_FIELDS*8-1:0] alm_i,
  output logic                  match_o
);
  logic [N_FIELDS-1:0] fld_ok;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    logic [7:0] a, n;
    assign a = alm_i[i*8 +: 8];
    assign n = now_i[i*8 +: 8];
    assign fld_ok[i] = (a[7:6] == 2'b11) || (a == n);
  end

  assign match_o = &fld_ok;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_bcd_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int UIP_LEAD = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              uip_o,
  output logic              update_done_o,
  output logic              alarm_o
);
  localparam int N_ALM = 3;

  rtc_time_t  t;
  logic [7:0] nx_sec, nx_min, nx_hour;
  logic [7:0] alm_sec_q, alm_min_q, alm_hour_q;
  logic [6:0] ctl_a_q;
  logic [7:0] ctl_b_q, ctl_d_q;
  logic [1:0] flags_q, flag_clr, flag_set;
  logic       uip, adv, match, done_q, alarm_q;

  function automatic logic hit(input int a);
    return we_i && (addr_i == ADDR_W'(a));
  endfunction

  rtc_update_seq #(.UIP_LEAD(UIP_LEAD)) u_seq (
    .clk_i, .rst_ni, .tick_i,
    .hold_i (ctl_b_q[7]),
    .uip_o  (uip),
    .adv_o  (adv)
  );

  rtc_time_chain #(.ADDR_W(ADDR_W)) u_chain (
    .clk_i, .rst_ni,
    .adv_i     (adv),
    .we_i, .addr_i, .wdata_i,
    .time_o    (t),
    .nx_sec_o  (nx_sec),
    .nx_min_o  (nx_min),
    .nx_hour_o (nx_hour)
  );

  rtc_alarm_cmp #(.N_FIELDS(N_ALM)) u_alm (
    .now_i   ({nx_hour, nx_min, nx_sec}),
    .alm_i   ({alm_hour_q, alm_min_q, alm_sec_q}),
    .match_o (match)
  );

  assign flag_clr = hit(REG_CC) ? wdata_i[1:0] : 2'b00;
  assign flag_set = {adv, adv && match};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_sec_q  <= 8'h00;
      alm_min_q  <= 8'h00;
      alm_hour_q <= 8'h00;
      ctl_a_q    <= 7'h00;
      ctl_b_q    <= 8'h00;
      ctl_d_q    <= 8'h00;
      flags_q    <= 2'b00;
      done_q     <= 1'b0;
      alarm_q    <= 1'b0;
    end else begin
      if (hit(REG_ASEC))  alm_sec_q  <= wdata_i;
      if (hit(REG_AMIN))  alm_min_q  <= wdata_i;
      if (hit(REG_AHOUR)) alm_hour_q <= wdata_i;
      if (hit(REG_CA))    ctl_a_q    <= wdata_i[6:0];
      if (hit(REG_CB))    ctl_b_q    <= wdata_i;
      if (hit(REG_CD))    ctl_d_q    <= wdata_i;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      done_q  <= adv;
      alarm_q <= adv && match;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      ADDR_W'(REG_SEC):   rdata_o = t.sec;
      ADDR_W'(REG_ASEC):  rdata_o = alm_sec_q;
      ADDR_W'(REG_MIN):   rdata_o = t.minute;
      ADDR_W'(REG_AMIN):  rdata_o = alm_min_q;
      ADDR_W'(REG_HOUR):  rdata_o = t.hour;
      ADDR_W'(REG_AHOUR): rdata_o = alm_hour_q;
      ADDR_W'(REG_DOW):   rdata_o = t.dow;
      ADDR_W'(REG_DATE):  rdata_o = t.date;
      ADDR_W'(REG_MON):   rdata_o = t.mon;
      ADDR_W'(REG_YEAR):  rdata_o = t.year;
      ADDR_W'(REG_CA):    rdata_o = {uip, ctl_a_q};
      ADDR_W'(REG_CB):    rdata_o = ctl_b_q;
      ADDR_W'(REG_CC):    rdata_o = {6'b0, flags_q};
      ADDR_W'(REG_CD):    rdata_o = ctl_d_q;
      ADDR_W'(REG_CENT):  rdata_o = t.cent;
      default:            rdata_o = 8'h00;
    endcase
  end

  assign uip_o         = uip;
  assign update_done_o = done_q;
  assign alarm_o       = alarm_q;

  assert_done_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_done_o |-> flags_q[1]);
  assert_alarm_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> (update_done_o && flags_q[0]));
  assert_done_after_uip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(update_done_o) |-> $fell(uip_o));
endmodule

// File: tb/rtc_bcd_core_tb.sv
`timescale 1ns/1ps
module rtc_bcd_core_tb;
  localparam int ADDR_W = 7;
  localparam int LEAD   = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0] wdata_i = 8'h00, rdata_o;
  logic uip_o, update_done_o, alarm_o;

  int n_tests = 0, n_fail = 0;

  rtc_bcd_core #(.ADDR_W(ADDR_W), .UIP_LEAD(LEAD)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  // reference model
  logic [7:0] mreg [0:127];
  int  m_left;
  bit  m_done, m_alm;

  function automatic int dec(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic bit alm_ok(input logic [7:0] a, input logic [7:0] n);
    return (a[7:6] == 2'b11) || (a == n);
  endfunction

  function automatic logic [7:0] m_read(input int a);
    if (a <= 9 || a == 11 || a == 13 || a == 50) return mreg[a];
    if (a == 10) return {(m_left > 0) ? 1'b1 : 1'b0, mreg[10][6:0]};
    if (a == 12) return mreg[12] & 8'h03;
    return 8'h00;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 128; i++) mreg[i] = 8'h00;
    mreg[6] = 8'h01; mreg[7] = 8'h01; mreg[8] = 8'h01; mreg[50] = 8'h20;
    m_left = 0; m_done = 0; m_alm = 0;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      bit hold, upd, hit;
      logic [1:0] clr, setb;
      int a;
      hold = mreg[11][7];
      upd = 0; hit = 0;
      if (m_left > 0) begin
        if (hold) m_left = 0;
        else begin
          m_left--;
          if (m_left == 0) upd = 1;
        end
      end else if (tick_i && !hold) m_left = LEAD;
      if (upd) begin
        int s, mi, h, w, d, mo, y, dim;
        s = dec(mreg[0] & 8'h7F); mi = dec(mreg[2] & 8'h7F); h = dec(mreg[4] & 8'h3F);
        w = int'(mreg[6] & 8'h07); d = dec(mreg[7] & 8'h3F); mo = dec(mreg[8] & 8'h1F);
        y = dec(mreg[9]);
        if (mo == 2) dim = (y % 4 == 0) ? 29 : 28;
        else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
        else dim = 31;
        s++;
        if (s == 60) begin
          s = 0; mi++;
          if (mi == 60) begin
            mi = 0; h++;
            if (h == 24) begin
              h = 0; w = (w >= 7) ? 1 : w + 1; d++;
              if (d > dim) begin
                d = 1; mo++;
                if (mo == 13) begin
                  mo = 1; y++;
                  if (y == 100) begin y = 0; mreg[50] = 8'h20; end
                end
              end
            end
          end
        end
        mreg[0] = bcd(s); mreg[2] = bcd(mi); mreg[4] = bcd(h); mreg[6] = 8'(w);
        mreg[7] = bcd(d); mreg[8] = bcd(mo); mreg[9] = bcd(y);
        hit = alm_ok(mreg[1], mreg[0]) && alm_ok(mreg[3], mreg[2]) && alm_ok(mreg[5], mreg[4]);
      end
      clr = 2'b00;
      a = int'(addr_i);
      if (we_i) begin
        if (a == 0) mreg[0] = wdata_i & 8'h7F;
        else if (a == 10) mreg[10] = wdata_i & 8'h7F;
        else if (a == 12) clr = wdata_i[1:0];
        else if (a <= 13 || a == 50) mreg[a] = wdata_i;
      end
      setb = {upd, upd && hit};
      mreg[12] = {6'b0, (mreg[12][1:0] & ~clr) | setb};
      m_done = upd;
      m_alm = upd && hit;
    end
  end

  // cycle compare
  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      logic [7:0] e;
      e = m_read(int'(addr_i));
      n_tests++;
      if (rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s cycle rdata addr=%h act=%h exp=%h",
                 (addr_i == 7'h0A) ? "R4" : (addr_i == 7'h0C) ? "R5" : (addr_i == 7'h32) ? "R7" : "R2",
                 addr_i, rdata_o, e);
      end
      n_tests++;
      if (uip_o !== (m_left > 0)) begin
        n_fail++; $display("FAIL R4 cycle uip act=%b exp=%b", uip_o, m_left > 0);
      end
      n_tests++;
      if (update_done_o !== m_done) begin
        n_fail++; $display("FAIL R5 cycle done act=%b exp=%b", update_done_o, m_done);
      end
      n_tests++;
      if (alarm_o !== m_alm) begin
        n_fail++; $display("FAIL R9 cycle alarm act=%b exp=%b", alarm_o, m_alm);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++; $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic expect_reg(input int a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    addr_i = ADDR_W'(a);
    #1 chk(req, rdata_o, exp);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                          input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(4, h); wr(2, mi); wr(0, s); wr(6, w); wr(7, d); wr(8, mo); wr(9, y);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk_i) rst_ni = 1'b1;
    // R1 reset map
    expect_reg(0, 8'h00, "R1 sec"); expect_reg(6, 8'h01, "R1 dow");
    expect_reg(7, 8'h01, "R1 date"); expect_reg(8, 8'h01, "R1 month");
    expect_reg(50, 8'h20, "R1 century"); expect_reg(11, 8'h00, "R1 ctrlB");
    wr(32, 8'hAA); expect_reg(32, 8'h00, "R1 unmapped");

    // R2 + R6 non-leap February
    set_time(8'h23, 8'h59, 8'h58, 8'h07, 8'h28, 8'h02, 8'h23);
    tick(); idle(LEAD + 2);
    expect_reg(0, 8'h59, "R2 sec step");
    tick(); idle(LEAD + 2);
    expect_reg(0, 8'h00, "R2 sec wrap"); expect_reg(2, 8'h00, "R2 min wrap");
    expect_reg(4, 8'h00, "R2 hour wrap"); expect_reg(6, 8'h01, "R2 dow wrap");
    expect_reg(7, 8'h01, "R6 feb28 wrap"); expect_reg(8, 8'h03, "R6 month carry");

    // R6 leap year
    set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24);
    tick(); idle(LEAD + 2);
    expect_reg(7, 8'h29, "R6 leap feb29"); expect_reg(8, 8'h02, "R6 leap month");
    set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h29, 8'h02, 8'h24);
    tick(); idle(LEAD + 2);
    expect_reg(7, 8'h01, "R6 leap wrap"); expect_reg(8, 8'h03, "R6 leap carry");
    set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h24);
    tick(); idle(LEAD + 2);
    expect_reg(7, 8'h01, "R6 april wrap"); expect_reg(8, 8'h05, "R6 april carry");

    // R7 century
    wr(50, 8'h19);
    set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    tick(); idle(LEAD + 2);
    expect_reg(9, 8'h00, "R7 year wrap"); expect_reg(8, 8'h01, "R7 month");
    expect_reg(50, 8'h20, "R7 century");

    // R4 flag timing
    wr(12, 8'h03);
    tick();
    for (int k = 0; k < LEAD; k++) begin
      #1 chk("R4 uip high", {7'b0, uip_o}, 8'h01);
      @(negedge clk_i);
    end
    #1 chk("R4 uip low", {7'b0, uip_o}, 8'h00);
    chk("R5 done pulse", {7'b0, update_done_o}, 8'h01);
    @(negedge clk_i); #1 chk("R5 done single", {7'b0, update_done_o}, 8'h00);
    wr(10, 8'h80); expect_reg(10, 8'h00, "R4 bit7 read-only");

    // R3 hold
    wr(11, 8'h80); wr(0, 8'h10);
    tick(); #1 chk("R3 no uip", {7'b0, uip_o}, 8'h00);
    idle(LEAD + 2); expect_reg(0, 8'h10, "R3 frozen");
    wr(11, 8'h00);
    tick(); wr(11, 8'h80); idle(LEAD + 2);
    expect_reg(0, 8'h10, "R3 cancel"); wr(11, 8'h00);

    // R8 unused bits
    wr(2, 8'h85); expect_reg(2, 8'h85, "R8 min kept");
    wr(0, 8'hC5); expect_reg(0, 8'h45, "R8 sec masked");
    tick(); idle(LEAD + 2);
    expect_reg(2, 8'h05, "R8 min cleared"); expect_reg(0, 8'h46, "R8 sec step");

    // R9 alarm + R5 W1C
    wr(12, 8'h03);
    wr(0, 8'h04); wr(1, 8'h05); wr(3, 8'hC0); wr(5, 8'hFF);
    tick(); idle(LEAD + 2);
    expect_reg(12, 8'h03, "R9 alarm flag");
    wr(12, 8'h01); expect_reg(12, 8'h02, "R9 w1c alarm");
    wr(12, 8'h02); expect_reg(12, 8'h00, "R5 w1c done");
    tick(); idle(LEAD + 2);
    expect_reg(12, 8'h02, "R9 no match");

    // R10 control access during update, tick while pending
    wr(12, 8'h03);
    tick();
    wr(10, 8'h7F); expect_reg(10, 8'hFF, "R10 ctrlA during uip");
    idle(LEAD + 2); expect_reg(10, 8'h7F, "R10 ctrlA after");
    wr(0, 8'h20);
    tick(); wr(13, 8'h5A); tick(); idle(LEAD + 4);
    expect_reg(13, 8'h5A, "R10 ctrlD");
    expect_reg(0, 8'h21, "R10 extra tick ignored");

    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule